// File: doc/BRIEF.md
# Packed-Symbol Error Pattern Applier

This block sits behind a Reed-Solomon decoder on a NAND page read path. The decoder reports up to four symbol error locations, each with a 12-bit error pattern. The page buffer holds a 2048-byte data area, and the spare bytes follow it at addresses 2048 and up in one byte address space. Code symbols are 12 bits wide and packed across byte boundaries, so two symbols share three bytes. The block turns each location into the one or two byte addresses it touches and the masks shifted for each byte. It then XORs each mask into the buffer through a single-port byte memory, with a read followed by a write.

A job starts on a one-cycle `start` pulse. The position list, pattern list and entry count are captured on that cycle. Before any write, the block checks every active entry. If the count or any entry is invalid, the job ends at once with `fail` set and the buffer is not touched. Otherwise the entries are applied in slot order. `done` then pulses with the number of corrected symbols.

The controller is one state machine with these states:
- S_IDLE: waits for `start`.
- S_CHECK: validates the captured job.
- S_RD_HI and S_WR_HI: update the first byte of an entry.
- S_RD_LO and S_WR_LO: update the second byte of an entry.
- S_FINISH: pulses `done`.

Its transitions are:
- start: S_IDLE to S_CHECK.
- reject or empty: S_CHECK to S_FINISH.
- go: S_CHECK to S_RD_HI.
- read-issued: S_RD_HI to S_WR_HI, and S_RD_LO to S_WR_LO.
- split: S_WR_HI to S_RD_LO.
- single-next: S_WR_HI to S_RD_HI, when position 0 is not the last entry.
- single-last: S_WR_HI to S_FINISH, when position 0 is the last entry.
- next: S_WR_LO to S_RD_HI.
- last: S_WR_LO to S_FINISH.
- release: S_FINISH to S_IDLE.

Top module: `nand_fix_apply`

## Requirements
- R1: For an odd position p of 1365 or less, pattern bits [11:4] are XORed into byte floor(3p/2), and pattern bits [3:0] shifted up by four are XORed into byte floor(3p/2)+1.
- R2: For an even position p from 2 to 1364, pattern bits [11:8] (in the low nibble) are XORed into byte 3p/2−1, and pattern bits [7:0] are XORed into byte 3p/2.
- R3: Position 0 carries only eight data bits. Its pattern is XORed into byte 0 alone, with one read and one write. If the pattern is above 0xFF, the job fails.
- R4: Position 1365 straddles the two areas. Pattern bits [11:4] go to data byte 2047 and the low nibble, shifted up by four, goes to spare byte 0 at address 2048.
- R5: Positions 1366 to 1374 follow the odd and even rules of R1 and R2 and land in the spare area at address 2048+k for spare byte k. No memory access goes beyond address 2111.
- R6: The job fails if the count is above 4 or any active entry has a position above 1374. On failure there are no memory writes and `fixed_count` is 0. Slots at or beyond the count are never examined.
- R7: `done` is a one-cycle pulse. On success, `fixed_count` equals the entry count, and a count of 0 finishes with 0. Entry i occupies `err_pos[11i+10:11i]` and `err_pat[12i+11:12i]`. Entries are applied in order, so a repeated position accumulates by XOR.
- R8: Every byte update is a read (`mem_rd`), then a write (`mem_wr`) to the same address on the next cycle. `mem_rdata` is expected one cycle after the read, and `mem_rd` and `mem_wr` are never high together.
- R9: Counting from the cycle in which `start` is sampled, `done` is high 1 cycle later on failure. On success it is high 1+4n−2z cycles later, for n entries of which z are at position 0.
- R10: A `start` pulse while the block is busy is ignored, and the job in progress finishes with its own inputs.
- R11: After reset, `busy`, `done`, `fail`, `mem_rd` and `mem_wr` are low, and no memory access occurs while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a job; inputs are captured on this cycle |
| err_count | input | 3 | Number of active entries |
| err_pos | input | 44 | Four 11-bit symbol positions, slot 0 in the low bits |
| err_pat | input | 48 | Four 12-bit error patterns, slot 0 in the low bits |
| mem_addr | output | 12 | Byte address into the page buffer |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fail | output | 1 | Job rejected; valid with `done` |
| fixed_count | output | 3 | Symbols corrected; valid with `done` |

## Verification
The assertions check the memory handshake on every cycle: a read is always followed by a write to the same address, the strobes never overlap, and every access stays within the buffer. They also check that the block is quiet when idle, that `done` lasts one cycle, and that a failed job reports a count of zero. The bench scenarios are the only way to show the byte mapping itself: the odd/even split, the padded first symbol, the straddling symbol and the spare offsets. The same holds for rejection without writes, XOR accumulation on repeated positions, cycle latency, and the block ignoring `start` while busy. For these, the bench compares the whole buffer and the write count against its own model.

// File: rtl/nand_fix_pkg.sv
package nand_fix_pkg;
    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_RD_HI,
        S_WR_HI,
        S_RD_LO,
        S_WR_LO,
        S_FINISH
    } fix_state_t;
endpackage

// File: rtl/nand_sym_map.sv
module nand_sym_map
    import nand_fix_pkg::*;
#(
    parameter int POS_W   = 11,
    parameter int ADDR_W  = 12,
    parameter int MAX_POS = 1374
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [SYM_W-1:0]  pat,
    output logic [ADDR_W-1:0] addr_hi,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [BYTE_W-1:0] mask_hi,
    output logic [BYTE_W-1:0] mask_lo,
    output logic              single,
    output logic              bad
);
    localparam int TRI_W = POS_W + 2;

    logic [TRI_W-1:0]  triple;
    logic [ADDR_W-1:0] half;
    logic              odd;
    logic              zero;

    always_comb begin
        triple  = {2'b00, pos} * TRI_W'(3);
        half    = ADDR_W'(triple >> 1);
        odd     = pos[0];
        zero    = (pos == '0);
        single  = zero;
        addr_lo = half;
        if (zero) begin
            addr_hi = '0;
            mask_hi = pat[7:0];
            mask_lo = '0;
        end else if (odd) begin
            addr_hi = half;
            addr_lo = half + ADDR_W'(1);
            mask_hi = pat[11:4];
            mask_lo = {pat[3:0], 4'b0000};
        end else begin
            addr_hi = half - ADDR_W'(1);
            mask_hi = {4'b0000, pat[11:8]};
            mask_lo = pat[7:0];
        end
        bad = (pos > POS_W'(MAX_POS)) || (zero && (pat[11:8] != 4'h0));
    end
endmodule

// File: rtl/nand_fix_lanes.sv
module nand_fix_lanes
    import nand_fix_pkg::*;
#(
    parameter int MAX_ERR = 4,
    parameter int POS_W   = 11,
    parameter int ADDR_W  = 12,
    parameter int MAX_POS = 1374,
    parameter int CNT_W   = $clog2(MAX_ERR + 1)
) (
    input  logic [MAX_ERR*POS_W-1:0]           pos_flat,
    input  logic [MAX_ERR*SYM_W-1:0]           pat_flat,
    input  logic [CNT_W-1:0]                   count,
    output logic [MAX_ERR-1:0][ADDR_W-1:0]     addr_hi,
    output logic [MAX_ERR-1:0][ADDR_W-1:0]     addr_lo,
    output logic [MAX_ERR-1:0][BYTE_W-1:0]     mask_hi,
    output logic [MAX_ERR-1:0][BYTE_W-1:0]     mask_lo,
    output logic [MAX_ERR-1:0]                 single,
    output logic                               reject
);
    logic [MAX_ERR-1:0] lane_bad;
    logic [MAX_ERR-1:0] lane_hit;

    for (genvar i = 0; i < MAX_ERR; i++) begin : g_lane
        nand_sym_map #(
            .POS_W  (POS_W),
            .ADDR_W (ADDR_W),
            .MAX_POS(MAX_POS)
        ) u_map (
            .pos    (pos_flat[i*POS_W +: POS_W]),
            .pat    (pat_flat[i*SYM_W +: SYM_W]),
            .addr_hi(addr_hi[i]),
            .addr_lo(addr_lo[i]),
            .mask_hi(mask_hi[i]),
            .mask_lo(mask_lo[i]),
            .single (single[i]),
            .bad    (lane_bad[i])
        );
        assign lane_hit[i] = lane_bad[i] && (CNT_W'(i) < count);
    end

    assign reject = (count > CNT_W'(MAX_ERR)) || (|lane_hit);
endmodule

// File: rtl/nand_fix_apply.sv
module nand_fix_apply
    import nand_fix_pkg::*;
#(
    parameter int MAX_ERR     = 4,
    parameter int POS_W       = 11,
    parameter int ADDR_W      = 12,
    parameter int MAX_POS     = 1374,
    parameter int CNT_W       = $clog2(MAX_ERR + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         err_count,
    input  logic [MAX_ERR*POS_W-1:0] err_pos,
    input  logic [MAX_ERR*SYM_W-1:0] err_pat,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_rd,
    output logic                     mem_wr,
    output logic [BYTE_W-1:0]        mem_wdata,
    input  logic [BYTE_W-1:0]        mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic                     fail,
    output logic [CNT_W-1:0]         fixed_count
);
    localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

    fix_state_t state, nxt;

    logic [MAX_ERR*POS_W-1:0] pos_q;
    logic [MAX_ERR*SYM_W-1:0] pat_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [IDX_W-1:0]         idx_q;
    logic                     fail_q;
    logic [CNT_W-1:0]         fixed_q;

    logic [MAX_ERR-1:0][ADDR_W-1:0] l_addr_hi, l_addr_lo;
    logic [MAX_ERR-1:0][BYTE_W-1:0] l_mask_hi, l_mask_lo;
    logic [MAX_ERR-1:0]             l_single;
    logic                           reject;
    logic                           last;
    logic                           cur_single;

    nand_fix_lanes #(
        .MAX_ERR(MAX_ERR),
        .POS_W  (POS_W),
        .ADDR_W (ADDR_W),
        .MAX_POS(MAX_POS),
        .CNT_W  (CNT_W)
    ) u_lanes (
        .pos_flat(pos_q),
        .pat_flat(pat_q),
        .count   (cnt_q),
        .addr_hi (l_addr_hi),
        .addr_lo (l_addr_lo),
        .mask_hi (l_mask_hi),
        .mask_lo (l_mask_lo),
        .single  (l_single),
        .reject  (reject)
    );

    assign last       = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;
    assign cur_single = l_single[idx_q];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_CHECK;
            S_CHECK:  nxt = (reject || cnt_q == '0) ? S_FINISH : S_RD_HI;
            S_RD_HI:  nxt = S_WR_HI;
            S_WR_HI:  nxt = !cur_single ? S_RD_LO : (last ? S_FINISH : S_RD_HI);
            S_RD_LO:  nxt = S_WR_LO;
            S_WR_LO:  nxt = last ? S_FINISH : S_RD_HI;
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // Job capture and progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            pat_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            fail_q  <= 1'b0;
            fixed_q <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                pos_q <= err_pos;
                pat_q <= err_pat;
                cnt_q <= err_count;
            end
            if (state == S_CHECK) begin
                idx_q   <= '0;
                fail_q  <= reject;
                fixed_q <= reject ? '0 : cnt_q;
            end
            if (nxt == S_RD_HI && (state == S_WR_HI || state == S_WR_LO))
                idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Outputs
    always_comb begin
        mem_rd    = (state == S_RD_HI) || (state == S_RD_LO);
        mem_wr    = (state == S_WR_HI) || (state == S_WR_LO);
        mem_addr  = '0;
        mem_wdata = '0;
        if (state == S_RD_HI || state == S_WR_HI) begin
            mem_addr  = l_addr_hi[idx_q];
            mem_wdata = mem_rdata ^ l_mask_hi[idx_q];
        end else if (state == S_RD_LO || state == S_WR_LO) begin
            mem_addr  = l_addr_lo[idx_q];
            mem_wdata = mem_rdata ^ l_mask_lo[idx_q];
        end
        if (!mem_wr) mem_wdata = '0;
        busy        = (state != S_IDLE);
        done        = (state == S_FINISH);
        fail        = fail_q;
        fixed_count = fixed_q;
    end
endmodule

// File: rtl/nand_fix_apply_chk.sv
module nand_fix_apply_chk #(
    parameter int MAX_ERR   = 4,
    parameter int ADDR_W    = 12,
    parameter int BUF_BYTES = 2112,
    parameter int CNT_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [CNT_W-1:0]  fixed_count
);
    p_rd_then_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr && (mem_addr == $past(mem_addr)));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (int'(mem_addr) < BUF_BYTES));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(fixed_count) <= MAX_ERR));

    p_fail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (fixed_count == '0));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !done));
endmodule

bind nand_fix_apply nand_fix_apply_chk #(
    .MAX_ERR  (MAX_ERR),
    .ADDR_W   (ADDR_W),
    .BUF_BYTES(2112),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .fixed_count(fixed_count)
);

// File: tb/nand_fix_apply_test.sv
module nand_fix_apply_test;
    localparam int NBUF = 2112;
    localparam int DATA = 2048;

    typedef struct {
        bit fl;
        int cnt;
        int lat;
        int wr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  err_count = '0;
    logic [43:0] err_pos = '0;
    logic [47:0] err_pat = '0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr, busy, done, fail;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  fixed_count;

    logic [7:0] mem [NBUF];
    logic [7:0] refb [NBUF];
    logic       fill_en = 1'b0;
    int         seed = 0;
    int         wr_cnt = 0;
    int         cyc = 0;
    int         t_start = 0;
    int         wr_base = 0;
    int         compared = 0;
    int         mismatched = 0;
    bit         finished = 0;
    exp_t       q[$];
    int         pos_a[4];
    int         pat_a[4];

    always #4 clk = ~clk;

    nand_fix_apply uut (
        .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
        .err_pos(err_pos), .err_pat(err_pat), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fixed_count(fixed_count)
    );

    function automatic logic [7:0] fill_byte(int i, int s);
        return 8'((i * 13 + s * 29) ^ (i >> 3));
    endfunction

    // Buffer model with one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fill_en) begin
            for (int i = 0; i < NBUF; i++) mem[i] <= fill_byte(i, seed);
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Independent model, written from the data/spare split
    task automatic ref_apply(int p, int pat);
        int b;
        if (p == 0) begin
            refb[0] ^= 8'(pat);
        end else if (p == 1365) begin
            refb[2047]     ^= 8'(pat >> 4);
            refb[DATA + 0] ^= 8'(pat << 4);
        end else if (p > 1365) begin
            if (p % 2 == 1) begin
                b = (3 * p) / 2 - 2048;
                refb[DATA + b]     ^= 8'(pat >> 4);
                refb[DATA + b + 1] ^= 8'(pat << 4);
            end else begin
                b = (3 * p) / 2 - 2049;
                refb[DATA + b]     ^= 8'(pat >> 8);
                refb[DATA + b + 1] ^= 8'(pat);
            end
        end else if (p % 2 == 1) begin
            refb[(3 * p) / 2]     ^= 8'(pat >> 4);
            refb[(3 * p) / 2 + 1] ^= 8'(pat << 4);
        end else begin
            refb[(3 * p) / 2 - 1] ^= 8'(pat >> 8);
            refb[(3 * p) / 2]     ^= 8'(pat);
        end
    endtask

    // Driver: prepares buffer and expectations, then starts the job
    task automatic run_job(string req, int n, int s, bit poke_busy);
        exp_t e;
        bit   bad;
        int   z;
        seed = s;
        @(negedge clk) fill_en = 1'b1;
        @(negedge clk) fill_en = 1'b0;
        for (int i = 0; i < NBUF; i++) refb[i] = fill_byte(i, s);
        bad = (n > 4);
        z = 0;
        for (int i = 0; i < 4; i++) begin
            err_pos[i*11 +: 11] = 11'(pos_a[i]);
            err_pat[i*12 +: 12] = 12'(pat_a[i]);
            if (i < n) begin
                if (pos_a[i] > 1374) bad = 1;
                if (pos_a[i] == 0 && pat_a[i] > 255) bad = 1;
                if (pos_a[i] == 0) z++;
            end
        end
        if (!bad) for (int i = 0; i < n && i < 4; i++) ref_apply(pos_a[i], pat_a[i]);
        err_count = 3'(n);
        e.fl  = bad;
        e.cnt = bad ? 0 : n;
        e.lat = bad ? 1 : 1 + 4 * n - 2 * z;
        e.wr  = bad ? 0 : 2 * n - z;
        q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        t_start = cyc;
        wr_base = wr_cnt;
        if (poke_busy) begin
            // R10: a second start with a job that would fail
            @(negedge clk);
            start = 1'b1;
            err_count = 3'd1;
            err_pos[10:0] = 11'd1400;
            @(negedge clk);
            start = 1'b0;
        end
        wait (q.size() == 0);
        $display("job %s done", req);
    endtask

    // Monitor: pops expectations when done is seen
    initial begin
        exp_t e;
        int   diff;
        forever begin
            @(negedge clk);
            if (done && q.size() > 0) begin
                e = q.pop_front();
                chk("R6/R7 fail flag", int'(fail), int'(e.fl));
                chk("R7 fixed_count", int'(fixed_count), e.cnt);
                chk("R9 latency", cyc - t_start, e.lat);
                chk("R8 write count", wr_cnt - wr_base, e.wr);
                diff = -1;
                for (int i = 0; i < NBUF; i++)
                    if (!e.fl && diff < 0 && mem[i] !== refb[i]) diff = i;
                compared++;
                if (diff >= 0) begin
                    mismatched++;
                    $display("FAIL R1-map buffer byte %0d: actual %0h expected %0h",
                             diff, mem[diff], refb[diff]);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin pos_a[i] = 0; pat_a[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 strobes", int'(mem_rd | mem_wr), 0);
        chk("R11 fail", int'(fail), 0);

        // R1 odd position
        pos_a[0] = 1; pat_a[0] = 'hABC;
        run_job("R1", 1, 1, 0);
        // R2 even position
        pos_a[0] = 2; pat_a[0] = 'h5A3;
        run_job("R2", 1, 2, 0);
        // R3 position 0, legal pattern
        pos_a[0] = 0; pat_a[0] = 'h0C5;
        run_job("R3", 1, 3, 0);
        // R3 position 0, pattern above 0xFF fails
        pos_a[0] = 0; pat_a[0] = 'h100;
        run_job("R3_fail", 1, 4, 0);
        // R4 straddling symbol
        pos_a[0] = 1365; pat_a[0] = 'hFED;
        run_job("R4", 1, 5, 0);
        // R5 spare area, four entries mixed
        pos_a[0] = 1366; pat_a[0] = 'h123;
        pos_a[1] = 1367; pat_a[1] = 'h456;
        pos_a[2] = 1374; pat_a[2] = 'h789;
        pos_a[3] = 700;  pat_a[3] = 'hF0F;
        run_job("R5", 4, 6, 0);
        // R6 out-of-range position in the last active slot
        pos_a[0] = 10; pat_a[0] = 'h111;
        pos_a[1] = 1375; pat_a[1] = 'h222;
        run_job("R6_range", 2, 7, 0);
        // R6 count above four
        pos_a[1] = 11;
        run_job("R6_count", 5, 8, 0);
        // R6 inactive slots are not examined
        pos_a[0] = 3; pat_a[0] = 'hA5A;
        pos_a[1] = 0; pat_a[1] = 'h0FF;
        pos_a[2] = 2000; pat_a[2] = 'hFFF;
        pos_a[3] = 2047; pat_a[3] = 'hFFF;
        run_job("R6_inactive", 2, 9, 0);
        // R7 empty job
        run_job("R7_empty", 0, 10, 0);
        // R7 repeated position cancels by XOR
        pos_a[0] = 5; pat_a[0] = 'h3C7;
        pos_a[1] = 5; pat_a[1] = 'h3C7;
        run_job("R7_repeat", 2, 11, 0);
        // R10 start while busy
        pos_a[0] = 9; pat_a[0] = 'h9E1;
        pos_a[1] = 1364; pat_a[1] = 'h6B2;
        run_job("R10", 2, 12, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule